// File: doc/BRIEF.md
# Slot Bus-Master Request/Grant Arbiter

This block sits on the system board and settles which expansion slot may act as bus master. Every slot has one active-low request input and one active-low grant output. On each rising edge of the bus clock the arbiter samples all requests. When the bus is free, it grants exactly one requester. Pending requesters are served in rotating order, and the rotation starts just after the slot that held the bus last.

A granted master keeps the bus as long as its request stays asserted. If another slot asks for the bus, the arbiter withdraws the grant as a notice of preemption. The master then has a bounded number of clock edges to remove its request. A master that misses this window is recorded in a sticky per-slot timeout flag, and the arbiter returns to idle.

The arbiter also checks that a master leaves enough idle clocks between removing its request and asserting it again. A slot that re-requests too early is recorded in a sticky per-slot protocol-error flag. Slots that are configured as non-master never receive a grant, and the arbiter ignores their request pins entirely.

Top module: `slot_master_arbiter`

## Requirements
- R1: Requests and grants are active low. A request is sampled on the rising clock edge. A request sampled while the arbiter is idle asserts that slot's grant from the same edge, so the grant is visible in the following clock period.
- R2: At most one grant output is low at any time.
- R3: Pending requesters are chosen in rotating order, starting at the slot that follows the most recently granted one and wrapping from the highest index to slot 0. Between two owners there is always at least one clock period with no grant.
- R4: When the owner's request is sampled negated, its grant is negated at that same edge and the arbiter becomes idle.
- R5: While a slot holds the grant, an asserted request from any other eligible slot negates the owner's grant at that edge. This is the preemption notice.
- R6: After a preemption notice, the owner may release its request at any of the next RELEASE_WINDOW sampling edges (64 by default), including the last one. Such a release sets no timeout flag, and the next requester is granted one edge later.
- R7: If the preempted owner's request is still asserted at the RELEASE_WINDOW-th edge after the notice, the timeout flag bit of that slot (bit index = slot number) is set at that edge and stays set until reset. The arbiter then goes idle and grants the next slot in rotation.
- R8: If a slot's request is sampled asserted after fewer than MIN_GAP (default 2) consecutive negated samples that follow an asserted sample, that slot's protocol-error bit is set and stays set until reset. A gap of MIN_GAP or more negated samples sets no error.
- R9: A slot whose MASTER_MASK bit is 0 is never granted. Its request causes no grant, no preemption and no flag.
- R10: During and after reset all grants are high, both flag vectors are zero, and the rotation starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | NUM_SLOTS | Per-slot bus request, active low |
| grantN | output | NUM_SLOTS | Per-slot bus grant, active low |
| timeoutFlag | output | NUM_SLOTS | Sticky: preempted owner missed its release window |
| protoErr | output | NUM_SLOTS | Sticky: slot re-requested too soon after releasing |

## Verification
Two functions can act at the same clock edge. In the first case, the 64th edge after a preemption notice sees both the window limit and a possible release. The bench provokes this once with the release landing exactly on that edge, where no flag may be set. It provokes it again with the request still held, where the flag must appear at that edge and the next rotation slot must be granted one edge later. In the second case, a too-early re-request also wins the idle bus in the same cycle. The bench expects the grant and the protocol-error bit together. A behavioural reference model predicts grants and flags on every clock and compares them.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OWNED  = 2'd1,
    ST_NOTICE = 2'd2
  } arbState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic take;         // latch the round-robin pick as the new owner
    logic startWin;     // clear the release-window counter
    logic tickWin;      // advance the release-window counter
    logic flagTimeout;  // record a missed release for the owner
    logic grantOn;      // drive the owner's grant
  } arbStrobe_t;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_SLOTS = 4,
  localparam int IDXW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] req,
  input  logic [IDXW-1:0]      last,
  output logic [IDXW-1:0]      pick,
  output logic                 found
);

  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int off = 1; off <= NUM_SLOTS; off++) begin
      int idx;
      idx = (int'(last) + off) % NUM_SLOTS;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IDXW'(idx);
      end
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ownerReq,
  input  logic       otherReq,
  input  logic       winExpired,
  output arbStrobe_t strobe
);

  arbState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.grantOn = (state == ST_OWNED);
    case (state)
      ST_IDLE: begin
        if (anyReq) begin
          strobe.take = 1'b1;
          nextState   = ST_OWNED;
        end
      end
      ST_OWNED: begin
        if (!ownerReq) begin
          nextState = ST_IDLE;
        end else if (otherReq) begin
          strobe.startWin = 1'b1;
          nextState       = ST_NOTICE;
        end
      end
      ST_NOTICE: begin
        if (!ownerReq) begin
          nextState = ST_IDLE;
        end else if (winExpired) begin
          strobe.flagTimeout = 1'b1;
          nextState          = ST_IDLE;
        end else begin
          strobe.tickWin = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R4: owner release returns the bus to idle
  a_r4_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OWNED && !ownerReq) |=> (state == ST_IDLE));

  // R5: a competing request turns ownership into a notice
  a_r5_preempt_notice: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OWNED && ownerReq && otherReq) |=> (state == ST_NOTICE));

  // R7: an expired window forces idle
  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NOTICE && ownerReq && winExpired) |=> (state == ST_IDLE));

  // R3: a new ownership is always preceded by an idle period
  a_r3_idle_between: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NOTICE) |=> (state != ST_OWNED));

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int                   NUM_SLOTS      = 4,
  parameter logic [NUM_SLOTS-1:0] MASTER_MASK    = '1,
  parameter int                   RELEASE_WINDOW = 64,
  parameter int                   MIN_GAP        = 2,
  localparam int IDXW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int WINW = (RELEASE_WINDOW > 1) ? $clog2(RELEASE_WINDOW) : 1,
  localparam int GAPW = $clog2(MIN_GAP + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] reqN,
  input  arbStrobe_t           strobe,
  output logic [NUM_SLOTS-1:0] grantN,
  output logic [NUM_SLOTS-1:0] timeoutFlag,
  output logic [NUM_SLOTS-1:0] protoErr,
  output logic                 anyReq,
  output logic                 ownerReq,
  output logic                 otherReq,
  output logic                 winExpired
);

  logic [NUM_SLOTS-1:0] eligible;
  logic [NUM_SLOTS-1:0] ownerOneHot;
  logic [IDXW-1:0]      lastOwner;
  logic [IDXW-1:0]      pick;
  logic [WINW-1:0]      winCnt;

  assign eligible = ~reqN & MASTER_MASK;

  arb_rr_pick #(.NUM_SLOTS(NUM_SLOTS)) uPick (
    .req   (eligible),
    .last  (lastOwner),
    .pick  (pick),
    .found (anyReq)
  );

  always_comb begin
    ownerOneHot            = '0;
    ownerOneHot[lastOwner] = 1'b1;
  end

  assign ownerReq   = |(eligible & ownerOneHot);
  assign otherReq   = |(eligible & ~ownerOneHot);
  assign winExpired = (winCnt == WINW'(RELEASE_WINDOW - 1));
  assign grantN     = ~(strobe.grantOn ? ownerOneHot : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOwner <= IDXW'(NUM_SLOTS - 1);
    end else if (strobe.take) begin
      lastOwner <= pick;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                winCnt <= '0;
    else if (strobe.startWin) winCnt <= '0;
    else if (strobe.tickWin)  winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   timeoutFlag <= '0;
    else if (strobe.flagTimeout) timeoutFlag <= timeoutFlag | ownerOneHot;
  end

  // Per-slot re-request spacing tracking
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (MASTER_MASK[i]) begin : g_master
      logic [GAPW-1:0] gapCnt;
      logic            errBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          gapCnt <= GAPW'(MIN_GAP);
          errBit <= 1'b0;
        end else if (eligible[i]) begin
          if (gapCnt != '0 && gapCnt < GAPW'(MIN_GAP)) errBit <= 1'b1;
          gapCnt <= '0;
        end else if (gapCnt < GAPW'(MIN_GAP)) begin
          gapCnt <= gapCnt + 1'b1;
        end
      end
      assign protoErr[i] = errBit;
    end else begin : g_quiet
      assign protoErr[i] = 1'b0;
    end
  end

  // R2: single grant
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~grantN));

  // R9: non-master slots stay silent
  a_r9_nonmaster_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((~grantN | protoErr | timeoutFlag) & ~MASTER_MASK) == '0);

  // R1: a low grant was backed by a sampled request at the previous edge
  a_r1_grant_backed: assert property (@(posedge clk) disable iff (!rstN)
    (~grantN & $past(reqN)) == '0);

  // R7: timeout flags are sticky
  a_r7_sticky_timeout: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timeoutFlag) & ~timeoutFlag) == '0);

  // R8: protocol-error flags are sticky
  a_r8_sticky_error: assert property (@(posedge clk) disable iff (!rstN)
    ($past(protoErr) & ~protoErr) == '0);

endmodule

// File: rtl/slot_master_arbiter.sv
module slot_master_arbiter
  import arb_pkg::*;
#(
  parameter int                   NUM_SLOTS      = 4,
  parameter logic [NUM_SLOTS-1:0] MASTER_MASK    = 4'b0111,
  parameter int                   RELEASE_WINDOW = 64,
  parameter int                   MIN_GAP        = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] reqN,
  output logic [NUM_SLOTS-1:0] grantN,
  output logic [NUM_SLOTS-1:0] timeoutFlag,
  output logic [NUM_SLOTS-1:0] protoErr
);

  arbStrobe_t strobe;
  logic anyReq, ownerReq, otherReq, winExpired;

  arb_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyReq     (anyReq),
    .ownerReq   (ownerReq),
    .otherReq   (otherReq),
    .winExpired (winExpired),
    .strobe     (strobe)
  );

  arb_datapath #(
    .NUM_SLOTS      (NUM_SLOTS),
    .MASTER_MASK    (MASTER_MASK),
    .RELEASE_WINDOW (RELEASE_WINDOW),
    .MIN_GAP        (MIN_GAP)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .reqN        (reqN),
    .strobe      (strobe),
    .grantN      (grantN),
    .timeoutFlag (timeoutFlag),
    .protoErr    (protoErr),
    .anyReq      (anyReq),
    .ownerReq    (ownerReq),
    .otherReq    (otherReq),
    .winExpired  (winExpired)
  );

endmodule

// File: tb/tb_slot_master_arbiter.sv
module tb_slot_master_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int WIN  = 64;
  localparam int GAP  = 2;
  localparam logic [N-1:0] MASK = 4'b0111;

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0] reqN;
  logic [N-1:0] grantN, timeoutFlag, protoErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R10";

  // behavioural reference model
  int mState;   // 0 idle, 1 owned, 2 notice
  int mOwner;
  int mCnt;
  int mGap [N];
  logic [N-1:0] mTo, mPe;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_master_arbiter #(
    .NUM_SLOTS(N), .MASTER_MASK(MASK), .RELEASE_WINDOW(WIN), .MIN_GAP(GAP)
  ) dut (
    .clk(clk), .rstN(rstN), .reqN(reqN),
    .grantN(grantN), .timeoutFlag(timeoutFlag), .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mState = 0; mOwner = N - 1; mCnt = 0; mTo = '0; mPe = '0;
    for (int i = 0; i < N; i++) mGap[i] = GAP;
  endtask

  task automatic modelStep();
    logic [N-1:0] cur;
    bit picked;
    cur = ~reqN & MASK;
    for (int i = 0; i < N; i++) begin
      if (cur[i]) begin
        if (mGap[i] != 0 && mGap[i] < GAP) mPe[i] = 1'b1;
        mGap[i] = 0;
      end else if (mGap[i] < GAP) mGap[i]++;
    end
    case (mState)
      0: begin
        picked = 0;
        for (int off = 1; off <= N; off++) begin
          int k;
          k = (mOwner + off) % N;
          if (!picked && cur[k]) begin picked = 1; mOwner = k; mState = 1; end
        end
      end
      1: begin
        if (!cur[mOwner]) mState = 0;
        else if ((cur & ~(N'(1) << mOwner)) != '0) begin mState = 2; mCnt = 0; end
      end
      default: begin
        if (!cur[mOwner]) mState = 0;
        else if (mCnt == WIN - 1) begin mTo[mOwner] = 1'b1; mState = 0; end
        else mCnt++;
      end
    endcase
  endtask

  function automatic logic [N-1:0] expGrant();
    return (mState == 1) ? ~(N'(1) << mOwner) : '1;
  endfunction

  task automatic compareAll();
    check(grantN === expGrant(), phase, "grant", 32'(grantN), 32'(expGrant()));
    check(timeoutFlag === mTo, phase, "timeout", 32'(timeoutFlag), 32'(mTo));
    check(protoErr === mPe, phase, "protoErr", 32'(protoErr), 32'(mPe));
    check($countones(~grantN) <= 1, "R2", "single grant", 32'(grantN), 32'(expGrant()));
  endtask

  task automatic step(input int n = 1);
    for (int s = 0; s < n; s++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic setReq(input logic [N-1:0] active);
    reqN = ~active;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    reqN = '1;
    modelReset();
    repeat (3) @(negedge clk);
    phase = "R10";
    check(grantN === 4'b1111, "R10", "reset grant", 32'(grantN), 32'hF);
    check(timeoutFlag === '0 && protoErr === '0, "R10", "reset flags",
          32'({timeoutFlag, protoErr}), 32'h0);
    rstN = 1'b1;
    step(2);

    // R1: single request granted one edge later
    phase = "R1";
    setReq(4'b0010); step();
    check(grantN === 4'b1101, "R1", "grant slot1", 32'(grantN), 32'hD);
    step(3);

    // R4: release drops grant
    phase = "R4";
    setReq(4'b0000); step();
    check(grantN === 4'b1111, "R4", "grant off", 32'(grantN), 32'hF);
    step(3);

    // R3 / R5: rotation and preemption
    phase = "R3";
    setReq(4'b0111); step();
    check(grantN === 4'b1011, "R3", "rotation picks slot2", 32'(grantN), 32'hB);
    phase = "R5";
    step();
    check(grantN === 4'b1111, "R5", "preempt notice", 32'(grantN), 32'hF);
    phase = "R3";
    setReq(4'b0011); step(2);
    check(grantN === 4'b1110, "R3", "wrap to slot0", 32'(grantN), 32'hE);
    step();
    setReq(4'b0010); step(2);
    check(grantN === 4'b1101, "R3", "then slot1", 32'(grantN), 32'hD);
    setReq(4'b0000); step(4);

    // R6: release on the last allowed edge
    phase = "R6";
    setReq(4'b0001); step();
    setReq(4'b0101); step();
    step(WIN - 1);
    setReq(4'b0100); step();
    check(timeoutFlag === '0, "R6", "no timeout at boundary", 32'(timeoutFlag), 32'h0);
    step();
    check(grantN === 4'b1011, "R6", "next requester", 32'(grantN), 32'hB);
    setReq(4'b0000); step(4);

    // R7: window expires
    phase = "R7";
    setReq(4'b0001); step();
    setReq(4'b0101); step();
    step(WIN - 1);
    check(timeoutFlag === '0, "R7", "before expiry", 32'(timeoutFlag), 32'h0);
    step();
    check(timeoutFlag === 4'b0001, "R7", "timeout slot0", 32'(timeoutFlag), 32'h1);
    step();
    check(grantN === 4'b1011, "R7", "rotation after timeout", 32'(grantN), 32'hB);
    setReq(4'b0000); step(4);

    // R8: spacing of re-requests
    phase = "R8";
    setReq(4'b0100); step(2);
    setReq(4'b0000); step(2);
    setReq(4'b0100); step();
    check(protoErr === '0, "R8", "two-cycle gap ok", 32'(protoErr), 32'h0);
    setReq(4'b0000); step(3);
    setReq(4'b0010); step(2);
    setReq(4'b0000); step();
    setReq(4'b0010); step();
    check(protoErr === 4'b0010, "R8", "one-cycle gap error", 32'(protoErr), 32'h2);
    check(grantN === 4'b1101, "R8", "grant with error", 32'(grantN), 32'hD);
    setReq(4'b0000); step(4);

    // R9: non-master slot ignored
    phase = "R9";
    setReq(4'b1000); step(3);
    check(grantN === 4'b1111, "R9", "no grant to slot3", 32'(grantN), 32'hF);
    setReq(4'b0001); step();
    setReq(4'b1001); step(3);
    check(grantN === 4'b1110, "R9", "no preemption by slot3", 32'(grantN), 32'hE);
    setReq(4'b0000); step(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule